// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block forms the effective data-space address for load and store operations of a small 8-bit processor core. It owns the three 16-bit indirect pointers (named X, Y and Z here). These sit in the six highest registers of the general register file and can be written a byte at a time through a register-write port. Each access request picks an addressing mode and, where the mode needs one, a pointer. The block then returns the address to use. In the same clock edge it writes back any pointer that the mode changes.

Five modes are supported. Direct takes a 16-bit address straight from the request. Plain indirect uses a pointer as it stands. Displacement adds a 6-bit unsigned offset to Y or Z. Pre-decrement lowers the pointer first and uses the lowered value. Post-increment uses the current value and then raises the pointer. A request that cannot be served is flagged and leaves every pointer as it was. Examples are an X base in displacement mode, an unused pointer code or an unused mode code. Instruction decode, the ALU and the memory array live elsewhere.

Top module: `adg_top`

## Requirements
- R1: After a synchronous active-low reset, all three pointers read 0x0000 and `addr_o`, `addr_vld_o` and `illegal_o` are 0.
- R2: A register write with `rf_we_i`=1 and register number 26..31 loads one pointer byte: 26/27 are X low/high, 28/29 are Y low/high, 30/31 are Z low/high. Writes to register numbers 0..25 leave all pointers unchanged.
- R3: Mode code 0 (direct) returns `direct_addr_i` unchanged for any 16-bit value, whatever `ptr_sel_i` is, and modifies no pointer.
- R4: Mode code 1 (plain indirect) returns the selected pointer (`ptr_sel_i` 0=X, 1=Y, 2=Z) and leaves it unchanged.
- R5: Mode code 2 (displacement) returns Y or Z plus the zero-extended `disp_i` (0..63), modulo 2^16, and leaves the pointer unchanged.
- R6: Mode code 3 (pre-decrement) returns the selected pointer minus one and stores that value back into the pointer; 0x0000 wraps to 0xFFFF.
- R7: Mode code 4 (post-increment) returns the selected pointer's current value and stores that value plus one; 0xFFFF wraps to 0x0000.
- R8: These requests are illegal: X in displacement mode, `ptr_sel_i`=3 in any pointer mode (codes 1..4), and mode codes 5..7. An illegal request gives `illegal_o`=1 and `addr_vld_o`=0, leaves `addr_o` unchanged and modifies no pointer.
- R9: Results appear on the outputs on the clock edge that samples the request. A pointer changed by a request is already updated for a request in the very next cycle.
- R10: If an access modifies a pointer in the same cycle that a register write targets a byte of that same pointer, the access result wins and the register write is dropped. A register write to a different pointer in that cycle still takes effect.
- R11: In a cycle without `req_i`, the next cycle has `addr_vld_o`=0 and `illegal_o`=0, and `addr_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Address request strobe |
| mode_i | input | 3 | Addressing mode code (0..4 valid) |
| ptr_sel_i | input | 2 | Pointer choice: 0=X, 1=Y, 2=Z |
| disp_i | input | 6 | Unsigned displacement |
| direct_addr_i | input | 16 | Address used in direct mode |
| rf_we_i | input | 1 | Register-file byte write strobe |
| rf_num_i | input | 5 | Register number of the write |
| rf_wdata_i | input | 8 | Byte written |
| addr_o | output | 16 | Effective address, registered |
| addr_vld_o | output | 1 | `addr_o` carries a fresh legal result |
| illegal_o | output | 1 | The previous request was illegal |

## Verification
The bench builds the block with its default parameters: 16-bit pointers, a 6-bit displacement, three pointers based at register 26, and displacement restricted to pointers 1 and up. With these values both wrap points of the 16-bit pointers can be reached by loading 0x0000 or 0xFFFF through two byte writes. Every mode code and every pointer code, including the unused ones, can be driven from the narrow mode and select fields. A 6-bit offset added to a base near 0xFFFF exercises carry-out wrap in displacement mode.

// File: rtl/adg_pkg.sv
// Shared definitions for the data address generator.
// Assumes mode codes are 3 bits wide; codes above AM_POSTINC are unused.
package adg_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } amode_e;
endpackage

// File: rtl/adg_ptr_file.sv
// Pointer storage: NUM_PTR pointers of ADDR_W bits, each mapped onto
// consecutive byte registers starting at REG_BASE (low byte first).
// Assumes ADDR_W is a multiple of 8. An access update to a pointer takes
// priority over a register-file byte write to the same pointer.
module adg_ptr_file #(
    parameter int ADDR_W   = 16,
    parameter int NUM_PTR  = 3,
    parameter int REG_BASE = 26,
    parameter int RNUM_W   = 5,
    parameter int SEL_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rf_we,
    input  logic [RNUM_W-1:0]                 rf_num,
    input  logic [7:0]                        rf_wdata,
    input  logic                              upd_en,
    input  logic [SEL_W-1:0]                  upd_sel,
    input  logic [ADDR_W-1:0]                 upd_val,
    output logic [NUM_PTR-1:0][ADDR_W-1:0]    ptr_o
);
    localparam int BYTES = ADDR_W / 8;

    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
        logic hit_upd;
        assign hit_upd = upd_en && (upd_sel == SEL_W'(p));
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            localparam int REG_NUM = REG_BASE + p * BYTES + b;
            logic [7:0] byte_q;
            // Hold one pointer byte: access update first, else register write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= '0;
                end else if (hit_upd) begin
                    byte_q <= upd_val[b*8 +: 8];
                end else if (rf_we && (rf_num == RNUM_W'(REG_NUM))) begin
                    byte_q <= rf_wdata;
                end
            end
            assign ptr_o[p][b*8 +: 8] = byte_q;
        end
    end
endmodule

// File: rtl/adg_addr_calc.sv
// Combinational effective-address and pointer-update calculation.
// Assumes the caller gates upd_en with its request strobe. Pointer codes at
// or above NUM_PTR are illegal in pointer modes; displacement needs a pointer
// index of at least DISP_MIN_SEL.
module adg_addr_calc
    import adg_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DISP_W       = 6,
    parameter int NUM_PTR      = 3,
    parameter int SEL_W        = 2,
    parameter int DISP_MIN_SEL = 1
) (
    input  logic [2:0]                        mode,
    input  logic [SEL_W-1:0]                  sel,
    input  logic [DISP_W-1:0]                 disp,
    input  logic [ADDR_W-1:0]                 direct_addr,
    input  logic [NUM_PTR-1:0][ADDR_W-1:0]    ptr_i,
    output logic [ADDR_W-1:0]                 ea,
    output logic                              legal,
    output logic                              upd_en,
    output logic [ADDR_W-1:0]                 upd_val
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              sel_ok;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] disp_ext;

    assign sel_ok   = (int'(sel) < NUM_PTR);
    assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, disp};

    // Pick the selected pointer, zero when the code is out of range.
    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (int'(sel) == i) cur = ptr_i[i];
        end
    end

    // Decode the mode into address, legality and writeback.
    always_comb begin
        ea      = '0;
        legal   = 1'b0;
        upd_en  = 1'b0;
        upd_val = cur;
        case (mode)
            AM_DIRECT: begin
                legal = 1'b1;
                ea    = direct_addr;
            end
            AM_IND: begin
                legal = sel_ok;
                ea    = cur;
            end
            AM_DISP: begin
                legal = sel_ok && (int'(sel) >= DISP_MIN_SEL);
                ea    = cur + disp_ext;
            end
            AM_PREDEC: begin
                legal   = sel_ok;
                ea      = cur - ONE;
                upd_en  = sel_ok;
                upd_val = cur - ONE;
            end
            AM_POSTINC: begin
                legal   = sel_ok;
                ea      = cur;
                upd_en  = sel_ok;
                upd_val = cur + ONE;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/adg_top.sv
// Data address generator top: keeps the X/Y/Z pointers, computes the
// effective address of each request and registers it with a valid and an
// illegal flag. A pointer change lands on the same edge as the address,
// so back-to-back requests see the new pointer.
module adg_top
    import adg_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DISP_W       = 6,
    parameter int NUM_PTR      = 3,
    parameter int REG_BASE     = 26,
    parameter int RNUM_W       = 5,
    parameter int SEL_W        = 2,
    parameter int DISP_MIN_SEL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [2:0]        mode_i,
    input  logic [SEL_W-1:0]  ptr_sel_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] direct_addr_i,
    input  logic              rf_we_i,
    input  logic [RNUM_W-1:0] rf_num_i,
    input  logic [7:0]        rf_wdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o,
    output logic              illegal_o
);
    logic [NUM_PTR-1:0][ADDR_W-1:0] ptrs;
    logic [ADDR_W-1:0]              ea;
    logic                           legal;
    logic                           calc_upd;
    logic [ADDR_W-1:0]              upd_val;

    adg_ptr_file #(
        .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .REG_BASE(REG_BASE),
        .RNUM_W(RNUM_W), .SEL_W(SEL_W)
    ) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rf_we    (rf_we_i),
        .rf_num   (rf_num_i),
        .rf_wdata (rf_wdata_i),
        .upd_en   (req_i && calc_upd),
        .upd_sel  (ptr_sel_i),
        .upd_val  (upd_val),
        .ptr_o    (ptrs)
    );

    adg_addr_calc #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W), .NUM_PTR(NUM_PTR),
        .SEL_W(SEL_W), .DISP_MIN_SEL(DISP_MIN_SEL)
    ) u_calc (
        .mode        (mode_i),
        .sel         (ptr_sel_i),
        .disp        (disp_i),
        .direct_addr (direct_addr_i),
        .ptr_i       (ptrs),
        .ea          (ea),
        .legal       (legal),
        .upd_en      (calc_upd),
        .upd_val     (upd_val)
    );

    // Register the result of each request; hold the address otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o     <= '0;
            addr_vld_o <= 1'b0;
            illegal_o  <= 1'b0;
        end else begin
            addr_vld_o <= req_i && legal;
            illegal_o  <= req_i && !legal;
            if (req_i && legal) addr_o <= ea;
        end
    end

    // Monitor copy of the selected pointer, used only by the checks below.
    logic [ADDR_W-1:0] cur_mon;
    logic              sel_ok_mon;
    assign sel_ok_mon = (int'(ptr_sel_i) < NUM_PTR);
    always_comb begin
        cur_mon = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (int'(ptr_sel_i) == i) cur_mon = ptrs[i];
        end
    end

    a_r3_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == AM_DIRECT) |=>
        (addr_vld_o && addr_o == $past(direct_addr_i)));

    a_r4_indirect: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == AM_IND && sel_ok_mon && !rf_we_i) |=>
        (addr_o == $past(cur_mon) && $stable(ptrs)));

    a_r6_predec: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == AM_PREDEC && sel_ok_mon) |=>
        (addr_vld_o && addr_o == $past(cur_mon) - ADDR_W'(1)));

    a_r7_postinc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == AM_POSTINC && sel_ok_mon) |=>
        (addr_vld_o && addr_o == $past(cur_mon)));

    a_r8_disp_x: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == AM_DISP && ptr_sel_i == '0 && !rf_we_i) |=>
        (illegal_o && !addr_vld_o && $stable(ptrs) && $stable(addr_o)));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!addr_vld_o && !illegal_o && $stable(addr_o)));
endmodule

// File: tb/tb_adg_top.sv
module tb_adg_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic [2:0]  mode_i;
    logic [1:0]  ptr_sel_i;
    logic [5:0]  disp_i;
    logic [15:0] direct_addr_i;
    logic        rf_we_i;
    logic [4:0]  rf_num_i;
    logic [7:0]  rf_wdata_i;
    logic [15:0] addr_o;
    logic        addr_vld_o;
    logic        illegal_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] pm [3];     // bench model of X, Y, Z
    logic [15:0] last_addr;  // last legal address expected on addr_o

    always #5 clk = ~clk;

    adg_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .ptr_sel_i(ptr_sel_i), .disp_i(disp_i), .direct_addr_i(direct_addr_i),
        .rf_we_i(rf_we_i), .rf_num_i(rf_num_i), .rf_wdata_i(rf_wdata_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal_of(input logic [2:0] m, input logic [1:0] s);
        case (m)
            3'd0:         return 1'b1;
            3'd1, 3'd3, 3'd4: return s != 2'd3;
            3'd2:         return (s == 2'd1) || (s == 2'd2);
            default:      return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] ea_of(input logic [2:0] m, input logic [1:0] s,
                                          input logic [5:0] d, input logic [15:0] da);
        logic [15:0] c;
        c = (s < 2'd3) ? pm[s] : 16'h0;
        case (m)
            3'd0:    return da;
            3'd2:    return c + {10'd0, d};
            3'd3:    return c - 16'd1;
            default: return c;
        endcase
    endfunction

    // Entered and left at a falling edge; consecutive calls keep req_i high.
    task automatic access(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                          input logic [15:0] da, input string tag);
        bit          lg;
        logic [15:0] e;
        req_i = 1'b1; mode_i = m; ptr_sel_i = s; disp_i = d; direct_addr_i = da;
        lg = legal_of(m, s);
        e  = ea_of(m, s, d, da);
        if (lg && m == 3'd3) pm[s] = pm[s] - 16'd1;
        if (lg && m == 3'd4) pm[s] = pm[s] + 16'd1;
        @(negedge clk);
        if (lg) begin
            chk(addr_vld_o && !illegal_o && addr_o == e, tag, {15'd0, addr_vld_o, addr_o}, {16'h1, e});
            last_addr = e;
        end else begin
            chk(illegal_o && !addr_vld_o && addr_o == last_addr, tag,
                {15'd0, illegal_o, addr_o}, {16'h1, last_addr});
        end
        req_i = 1'b0;
    endtask

    task automatic rf_write(input logic [4:0] n, input logic [7:0] v);
        rf_we_i = 1'b1; rf_num_i = n; rf_wdata_i = v;
        @(negedge clk);
        rf_we_i = 1'b0;
        if (n >= 5'd26) begin
            if (n[0]) pm[(n - 26) / 2][15:8] = v;
            else      pm[(n - 26) / 2][7:0]  = v;
        end
    endtask

    task automatic load_ptr(input logic [1:0] s, input logic [15:0] v);
        rf_write(5'(26 + 2 * s), v[7:0]);
        rf_write(5'(27 + 2 * s), v[15:8]);
    endtask

    // Read a pointer through plain indirect mode and compare with a literal.
    task automatic peek(input logic [1:0] s, input logic [15:0] v, input string tag);
        access(3'd1, s, 6'd0, 16'h0, tag);
        chk(addr_o == v, tag, {16'h0, addr_o}, {16'h0, v});
    endtask

    task automatic idle_chk(input string tag);
        @(negedge clk);
        chk(!addr_vld_o && !illegal_o && addr_o == last_addr, tag,
            {14'd0, addr_vld_o, illegal_o, addr_o}, {16'h0, last_addr});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; req_i = 1'b0; mode_i = '0; ptr_sel_i = '0; disp_i = '0;
        direct_addr_i = '0; rf_we_i = 1'b0; rf_num_i = '0; rf_wdata_i = '0;
        for (int i = 0; i < 3; i++) pm[i] = 16'h0;
        last_addr = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(addr_o == 16'h0 && !addr_vld_o && !illegal_o, "R1 outputs",
            {14'd0, addr_vld_o, illegal_o, addr_o}, 32'h0);
        peek(2'd0, 16'h0000, "R1 X zero");
        peek(2'd2, 16'h0000, "R1 Z zero");

        // R2: byte mapping and ignored low registers
        load_ptr(2'd0, 16'h1234);
        load_ptr(2'd1, 16'hABCD);
        load_ptr(2'd2, 16'h0F00);
        rf_write(5'd25, 8'hEE);
        rf_write(5'd0, 8'h77);
        peek(2'd0, 16'h1234, "R2 X bytes");
        peek(2'd1, 16'hABCD, "R2 Y bytes");
        peek(2'd2, 16'h0F00, "R2 Z bytes");

        // R3: direct with assorted selects
        access(3'd0, 2'd3, 6'd5, 16'hFFFF, "R3 direct high");
        access(3'd0, 2'd1, 6'd0, 16'h0000, "R3 direct zero");
        peek(2'd1, 16'hABCD, "R3 Y untouched");

        // R5: displacement bounds and wrap
        access(3'd2, 2'd1, 6'd0, 16'h0, "R5 disp zero");
        access(3'd2, 2'd2, 6'd63, 16'h0, "R5 disp max");
        chk(addr_o == 16'h0F3F, "R5 Z+63", {16'h0, addr_o}, 32'h0F3F);
        load_ptr(2'd2, 16'hFFF0);
        access(3'd2, 2'd2, 6'd63, 16'h0, "R5 disp wrap");
        chk(addr_o == 16'h002F, "R5 wrap value", {16'h0, addr_o}, 32'h002F);
        peek(2'd2, 16'hFFF0, "R5 Z unchanged");

        // R6 / R9: pre-decrement wrap, back-to-back
        load_ptr(2'd1, 16'h0000);
        access(3'd3, 2'd1, 6'd0, 16'h0, "R6 predec wrap");
        chk(addr_o == 16'hFFFF, "R6 wrap value", {16'h0, addr_o}, 32'hFFFF);
        access(3'd3, 2'd1, 6'd0, 16'h0, "R9 back-to-back predec");
        chk(addr_o == 16'hFFFE, "R9 sees update", {16'h0, addr_o}, 32'hFFFE);
        peek(2'd1, 16'hFFFE, "R6 Y stored");

        // R7 / R9: post-increment wrap, back-to-back
        load_ptr(2'd2, 16'hFFFF);
        access(3'd4, 2'd2, 6'd0, 16'h0, "R7 postinc old");
        chk(addr_o == 16'hFFFF, "R7 uses old", {16'h0, addr_o}, 32'hFFFF);
        access(3'd4, 2'd2, 6'd0, 16'h0, "R9 back-to-back postinc");
        chk(addr_o == 16'h0000, "R7 wrapped", {16'h0, addr_o}, 32'h0000);
        peek(2'd2, 16'h0001, "R7 Z stored");
        access(3'd4, 2'd0, 6'd0, 16'h0, "R7 postinc X");
        peek(2'd0, 16'h1235, "R7 X stored");

        // R8: illegal requests change nothing
        access(3'd2, 2'd0, 6'd9, 16'h0, "R8 X displacement");
        access(3'd3, 2'd3, 6'd0, 16'h0, "R8 bad pointer predec");
        access(3'd4, 2'd3, 6'd0, 16'h0, "R8 bad pointer postinc");
        access(3'd5, 2'd1, 6'd0, 16'h0, "R8 mode 5");
        access(3'd7, 2'd2, 6'd0, 16'h0, "R8 mode 7");
        peek(2'd0, 16'h1235, "R8 X intact");
        peek(2'd1, 16'hFFFE, "R8 Y intact");
        peek(2'd2, 16'h0001, "R8 Z intact");

        // R10: collision between access update and register write
        rf_we_i = 1'b1; rf_num_i = 5'd28; rf_wdata_i = 8'hAA;
        access(3'd3, 2'd1, 6'd0, 16'h0, "R10 predec vs write");
        rf_we_i = 1'b0;
        peek(2'd1, 16'hFFFD, "R10 access wins");
        rf_we_i = 1'b1; rf_num_i = 5'd31; rf_wdata_i = 8'h5A;
        access(3'd4, 2'd1, 6'd0, 16'h0, "R10 postinc with other write");
        rf_we_i = 1'b0;
        pm[2][15:8] = 8'h5A;
        peek(2'd2, 16'h5A01, "R10 other pointer written");

        // R11: idle cycles hold the address
        idle_chk("R11 idle one");
        idle_chk("R11 idle two");

        // Random mix checked against the bench model
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 5);
            if (r == 0) begin
                rf_write(5'($urandom_range(20, 31)), 8'($urandom));
            end else if (r == 1) begin
                idle_chk("R11 random idle");
            end else begin
                access(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                       6'($urandom), 16'($urandom), "R9 random access");
            end
        end
        peek(2'd0, pm[0], "R4 final X");
        peek(2'd1, pm[1], "R4 final Y");
        peek(2'd2, pm[2], "R4 final Z");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule